// File: doc/BRIEF.md
# Two-Phase Register-RAM Execution Core

This block is the timing core of a small 32-bit processor whose code and data both live in one dual-port register RAM of 512 words. Every instruction takes two clocks of issue time, and the clocks alternate between two phases. In phase 0 one RAM port fetches the next instruction while the other port writes back the result of an older one. In phase 1 both ports read the destination and source operands of the instruction that was just fetched. Operands are held in flip-flops for two full clocks while the ALU settles. The result is then written back in the next phase-0 cycle, four clocks after its fetch.

Because a result is written late, a one-entry forwarder compares the address being written with the fetch address and with the two operand addresses in flight. On a match it supplies the fresh result in place of the stale RAM data. A prefix instruction can supply destination and source addresses that replace the fields of the very next instruction. The replacement is applied before the fields drive the RAM. A taken jump redirects the fetch that happens in the cycle the jump writes back. The instruction already behind the jump is cancelled.

The core is held idle while `run` is low. In that state the RAM can be filled through a load port. Results are observed on the write-back bus, together with the zero flag, the fetch address and the phase.

Top module: `twop_core`

## Requirements
- R1: While `run` is high, `phase` is 0 in the first cycle and toggles on every clock. Phase 0 is the fetch and write-back cycle, and phase 1 is the operand-read cycle.
- R2: Instructions issue one every two clocks. Independent instructions at consecutive addresses write back in phase-0 cycles spaced exactly two clocks apart, and `wb_en` is never high in two consecutive cycles.
- R3: The instruction at address 0 is fetched in cycle 0 after `run` rises. An instruction fetched in cycle t drives `wb_en` in cycle t+4.
- R4: The instruction word carries the opcode at bits [31:28], the D field at [17:9] and the S field at [8:0]. Opcode 0 is a no-op. Opcode 1 (MOV) writes RAM[S] to D. Opcode 2 (ADD) writes RAM[D]+RAM[S] modulo 2^32 to D and sets `flag_z` exactly when that sum is zero.
- R5: An instruction that reads, as D or S, the register written by the instruction just before it sees the new value with no spacer.
- R6: A register written by an instruction and fetched as code two instructions later, with one spacer between them, executes its new contents.
- R7: Opcode 4 is a prefix. It writes nothing, and it replaces the D and S fields of the next instruction with its own D and S fields. The instruction after that one is unaffected.
- R8: Opcode 3 (JMP) writes nothing and jumps to the address in its S field. The target is fetched four clocks after the jump was fetched. The instruction behind the jump gets no write-back.
- R9: A prefix that is cancelled by a jump ahead of it leaves the fields of the jump target unchanged.
- R10: `flag_z` changes only when an ADD writes back. A cancelled ADD leaves it unchanged.
- R11: While in reset or while `run` is low: `wb_en`=0, `flag_z`=0, `fetch_pc`=0 and `phase`=0. In this state a load-port write stores its data into the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Core executes while high; the pipeline is cleared while low |
| ld_en | input | 1 | Load-port write strobe, honoured while `run` is low |
| ld_addr | input | 9 | Load-port RAM address |
| ld_data | input | 32 | Load-port write data |
| wb_en | output | 1 | A result is being written back this cycle |
| wb_addr | output | 9 | Write-back register address |
| wb_data | output | 32 | Write-back value |
| flag_z | output | 1 | Zero flag from the last ADD |
| fetch_pc | output | 9 | Address fetched in this cycle when `phase` is 0 |
| phase | output | 1 | 0: fetch and write-back, 1: operand read |

## Verification
The bench goes after the places where the late write-back meets an early read:
- An operand that depends on the previous result. Without operand forwarding it would produce a sum built from the stale register.
- An instruction rewritten one slot before it is fetched. Without instruction forwarding the old word would run, and the expected write-back would never appear.

Jumps are tested with an ADD of zero placed behind them. If cancellation were missing, that ADD would either write back or set the zero flag.

Prefixes are tested in two ways:
- A prefix followed by two instructions. A design that failed to clear the substitution would redirect the second one as well.
- A prefix sitting in a jump's shadow. A design that did not disarm it would redirect the jump target.

Sums that wrap to zero check the flag at the 32-bit boundary.

// File: rtl/twop_pkg.sv
`timescale 1ns/1ps
// Shared opcode encoding for the two-phase core.
// Assumes a 4-bit opcode in the top bits of each instruction word.
package twop_pkg;
    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 4'd0,
        OP_MOV = 4'd1,
        OP_ADD = 4'd2,
        OP_JMP = 4'd3,
        OP_ALT = 4'd4
    } op_e;
endpackage

// File: rtl/twop_regram.sv
`timescale 1ns/1ps
// Dual-port register RAM with registered reads.
// Port A only reads. Port B reads or writes.
// A read returns the contents from before any same-cycle write.
module twop_regram #(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] a_addr,
    output logic [DATA_W-1:0] a_q,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_we,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_q
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Port A: registered read.
    always_ff @(posedge clk) begin
        a_q <= mem[a_addr];
    end

    // Port B: write when enabled, registered read otherwise old data.
    always_ff @(posedge clk) begin
        if (b_we) begin
            mem[b_addr] <= b_wdata;
        end
        b_q <= mem[b_addr];
    end
endmodule

// File: rtl/twop_alu.sv
`timescale 1ns/1ps
// Stub ALU with move, add and jump.
// Purely combinational. The caller holds its inputs in flip-flops for two clocks.
module twop_alu
    import twop_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] d_val,
    input  logic [DATA_W-1:0] s_val,
    output logic [DATA_W-1:0] result,
    output logic              writes,
    output logic              sets_flag,
    output logic              jumps
);
    // Decode the operation and form its result.
    always_comb begin
        result    = '0;
        writes    = 1'b0;
        sets_flag = 1'b0;
        jumps     = 1'b0;
        case (op)
            OP_MOV: begin
                result = s_val;
                writes = 1'b1;
            end
            OP_ADD: begin
                result    = d_val + s_val;
                writes    = 1'b1;
                sets_flag = 1'b1;
            end
            OP_JMP: jumps = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/twop_fwd.sv
`timescale 1ns/1ps
// One-entry result forwarder.
// In phase 0 the value being written back replaces stale operand data, and it
// is remembered for the instruction word that arrives in phase 1.
// Assumes that a RAM read issued in the same cycle as a write returns old data.
module twop_fwd #(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ph,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] rd_d_addr,
    input  logic [ADDR_W-1:0] rd_s_addr,
    input  logic [DATA_W-1:0] ram_qa,
    input  logic [DATA_W-1:0] ram_qb,
    output logic [DATA_W-1:0] instr,
    output logic [DATA_W-1:0] d_val,
    output logic [DATA_W-1:0] s_val
);
    logic              i_hit;
    logic [DATA_W-1:0] i_data;

    // Remember whether this fetch collides with the concurrent write-back.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            i_hit  <= 1'b0;
            i_data <= '0;
        end else if (!ph) begin
            i_hit  <= wb_en && (wb_addr == fetch_addr);
            i_data <= wb_data;
        end
    end

    // Choose between fresh results and RAM outputs.
    always_comb begin
        instr = i_hit ? i_data : ram_qa;
        d_val = (wb_en && (wb_addr == rd_d_addr)) ? wb_data : ram_qa;
        s_val = (wb_en && (wb_addr == rd_s_addr)) ? wb_data : ram_qb;
    end
endmodule

// File: rtl/twop_subst.sv
`timescale 1ns/1ps
// D/S field substitution.
// A prefix arms replacement addresses that are muxed into the next
// instruction's fields before they address the RAM. The arming clears after
// one use, or when a taken jump cancels the prefix.
module twop_subst
    import twop_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ph,
    input  logic [DATA_W-1:0] instr,
    input  logic              kill,
    output logic [ADDR_W-1:0] d_addr,
    output logic [ADDR_W-1:0] s_addr
);
    localparam int unsigned OP_LSB = DATA_W - OP_W;

    logic              armed;
    logic [ADDR_W-1:0] sub_d;
    logic [ADDR_W-1:0] sub_s;
    op_e               op;

    assign op = op_e'(instr[DATA_W-1:OP_LSB]);

    // Mux the substituted fields ahead of the RAM address inputs.
    always_comb begin
        d_addr = armed ? sub_d : instr[2*ADDR_W-1:ADDR_W];
        s_addr = armed ? sub_s : instr[ADDR_W-1:0];
    end

    // Arm on a prefix, clear after one use or when the prefix is cancelled.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            armed <= 1'b0;
            sub_d <= '0;
            sub_s <= '0;
        end else if (ph) begin
            armed <= (op == OP_ALT);
            if (op == OP_ALT) begin
                sub_d <= instr[2*ADDR_W-1:ADDR_W];
                sub_s <= instr[ADDR_W-1:0];
            end
        end else if (kill) begin
            armed <= 1'b0;
        end
    end

    // R7: a substitution is consumed by exactly one non-prefix instruction.
    a_r7_prefix_one_shot: assert property (@(posedge clk) disable iff (!rst_n || !run)
        (ph && armed && op != OP_ALT) |=> !armed);
endmodule

// File: rtl/twop_core.sv
`timescale 1ns/1ps
// Two-phase execution core.
// Phase 0 fetches an instruction and writes back an older result.
// Phase 1 reads both operands of the fetched instruction.
// The ALU inputs sit in flip-flops for two clocks. A taken jump redirects the
// fetch and cancels the instruction behind it.
// Assumes DATA_W >= 2*ADDR_W + 4.
module twop_core
    import twop_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              flag_z,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              phase
);
    localparam int unsigned OP_LSB = DATA_W - OP_W;

    logic              ph;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] fetch_addr;
    logic              taken;

    logic              dec_valid;
    op_e               dec_op;
    logic [ADDR_W-1:0] dec_d;
    logic [ADDR_W-1:0] dec_s;

    logic              ex_valid;
    op_e               ex_op;
    logic [ADDR_W-1:0] ex_d;
    logic [ADDR_W-1:0] ex_s;
    logic [DATA_W-1:0] ex_dv;
    logic [DATA_W-1:0] ex_sv;

    logic [DATA_W-1:0] alu_res;
    logic              alu_wr;
    logic              alu_flag;
    logic              alu_jmp;

    logic [ADDR_W-1:0] ram_a_addr;
    logic [ADDR_W-1:0] ram_b_addr;
    logic              ram_b_we;
    logic [DATA_W-1:0] ram_b_wdata;
    logic [DATA_W-1:0] ram_qa;
    logic [DATA_W-1:0] ram_qb;

    logic [DATA_W-1:0] instr;
    logic [DATA_W-1:0] d_val;
    logic [DATA_W-1:0] s_val;
    logic [ADDR_W-1:0] sub_d_addr;
    logic [ADDR_W-1:0] sub_s_addr;

    twop_alu #(.DATA_W(DATA_W)) u_alu (
        .op(ex_op), .d_val(ex_dv), .s_val(ex_sv),
        .result(alu_res), .writes(alu_wr), .sets_flag(alu_flag), .jumps(alu_jmp)
    );

    // Write-back, jump and fetch-address selection in phase 0.
    always_comb begin
        wb_en      = run && !ph && ex_valid && alu_wr;
        taken      = run && !ph && ex_valid && alu_jmp;
        wb_addr    = ex_d;
        wb_data    = alu_res;
        fetch_addr = taken ? ex_s : pc;
        fetch_pc   = fetch_addr;
        phase      = ph;
    end

    // Time-share the RAM ports between the phases and the load port.
    always_comb begin
        ram_a_addr  = ph ? sub_d_addr : fetch_addr;
        ram_b_we    = run ? wb_en : ld_en;
        ram_b_wdata = run ? wb_data : ld_data;
        if (!run) begin
            ram_b_addr = ld_addr;
        end else begin
            ram_b_addr = ph ? sub_s_addr : wb_addr;
        end
    end

    twop_regram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .a_addr(ram_a_addr), .a_q(ram_qa),
        .b_addr(ram_b_addr), .b_we(ram_b_we), .b_wdata(ram_b_wdata), .b_q(ram_qb)
    );

    twop_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
        .clk(clk), .rst_n(rst_n), .run(run), .ph(ph),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .fetch_addr(fetch_addr), .rd_d_addr(dec_d), .rd_s_addr(dec_s),
        .ram_qa(ram_qa), .ram_qb(ram_qb),
        .instr(instr), .d_val(d_val), .s_val(s_val)
    );

    twop_subst #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_subst (
        .clk(clk), .rst_n(rst_n), .run(run), .ph(ph), .instr(instr),
        .kill(taken), .d_addr(sub_d_addr), .s_addr(sub_s_addr)
    );

    // Pipeline sequencing: decode in phase 1, operand latch and flag in phase 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph        <= 1'b0;
            pc        <= '0;
            dec_valid <= 1'b0;
            dec_op    <= OP_NOP;
            dec_d     <= '0;
            dec_s     <= '0;
            ex_valid  <= 1'b0;
            ex_op     <= OP_NOP;
            ex_d      <= '0;
            ex_s      <= '0;
            ex_dv     <= '0;
            ex_sv     <= '0;
            flag_z    <= 1'b0;
        end else begin
            ph <= ~ph;
            if (!ph) begin
                pc       <= fetch_addr + 1'b1;
                ex_valid <= dec_valid && !taken;
                ex_op    <= dec_op;
                ex_d     <= dec_d;
                ex_s     <= dec_s;
                ex_dv    <= d_val;
                ex_sv    <= s_val;
                if (wb_en && alu_flag) begin
                    flag_z <= (alu_res == '0);
                end
            end else begin
                dec_valid <= 1'b1;
                dec_op    <= op_e'(instr[DATA_W-1:OP_LSB]);
                dec_d     <= sub_d_addr;
                dec_s     <= sub_s_addr;
            end
        end
    end

    // R1: phases alternate every clock while running.
    a_r1_phase_lo_hi: assert property (@(posedge clk) disable iff (!rst_n || !run)
        !phase |=> phase);
    a_r1_phase_hi_lo: assert property (@(posedge clk) disable iff (!rst_n || !run)
        phase |=> !phase);
    // R2: at most one write-back per two clocks.
    a_r2_wb_gap: assert property (@(posedge clk) disable iff (!rst_n || !run)
        wb_en |=> !wb_en);
    // R8: the instruction behind a taken jump never writes back.
    a_r8_cancel_no_wb: assert property (@(posedge clk) disable iff (!rst_n || !run)
        taken |=> ##1 !wb_en);
    // R10: the flag is untouched unless an ADD writes back.
    a_r10_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n || !run)
        !(wb_en && ex_op == OP_ADD) |=> $stable(flag_z));
endmodule

// File: tb/twop_core_bench.sv
`timescale 1ns/1ps
module twop_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        ld_en = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic        wb_en;
    logic [8:0]  wb_addr;
    logic [31:0] wb_data;
    logic        flag_z;
    logic [8:0]  fetch_pc;
    logic        phase;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          ev_n;
    int          ev_cyc  [16];
    logic [8:0]  ev_addr [16];
    logic [31:0] ev_data [16];
    logic [8:0]  fp_t    [32];
    logic        ph_t    [32];
    logic        z_last;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] sum;
        logic        z;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0},
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1},
        '{32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1},
        '{32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1},
        '{32'h0000_1234, 32'hFFFF_FFFF, 32'h0000_1233, 1'b0}
    };

    twop_core u_twop_core (
        .clk(clk), .rst_n(rst_n), .run(run),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .flag_z(flag_z), .fetch_pc(fetch_pc), .phase(phase)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] mk(logic [3:0] op, int d, int s);
        logic [8:0] dd;
        logic [8:0] ss;
        dd = d[8:0];
        ss = s[8:0];
        return {op, 10'b0, dd, ss};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_ev(int i, int cyc, int addr, logic [31:0] data, string req);
        bit ok;
        ok = (i < ev_n) && (ev_cyc[i] == cyc) && (ev_addr[i] == addr[8:0]) && (ev_data[i] == data);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s event %0d: actual cyc=%0d addr=%0d data=%h expected cyc=%0d addr=%0d data=%h",
                     req, i, ev_cyc[i], ev_addr[i], ev_data[i], cyc, addr, data);
        end
    endtask

    task automatic load(int a, logic [31:0] d);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = a[8:0];
        ld_data = d;
        @(posedge clk);
        #1 ld_en = 1'b0;
    endtask

    task automatic clear_code();
        for (int a = 0; a < 8; a++) load(a, 32'h0);
    endtask

    task automatic run_prog(int n);
        ev_n = 0;
        for (int i = 0; i < 16; i++) begin
            ev_cyc[i] = -1; ev_addr[i] = '0; ev_data[i] = '0;
        end
        @(negedge clk);
        run = 1'b1;
        #1;
        for (int k = 0; k < n; k++) begin
            if (k < 32) begin
                fp_t[k] = fetch_pc;
                ph_t[k] = phase;
            end
            if (wb_en && ev_n < 16) begin
                ev_cyc[ev_n]  = k;
                ev_addr[ev_n] = wb_addr;
                ev_data[ev_n] = wb_data;
                ev_n++;
            end
            @(posedge clk);
            @(negedge clk);
            #1;
        end
        z_last = flag_z;
        run = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R11: reset state
        chk(wb_en == 1'b0, "R11", "reset wb_en", {31'b0, wb_en}, 32'h0);
        chk(flag_z == 1'b0, "R11", "reset flag_z", {31'b0, flag_z}, 32'h0);
        chk(fetch_pc == 9'd0, "R11", "reset fetch_pc", {23'b0, fetch_pc}, 32'h0);
        chk(phase == 1'b0, "R11", "reset phase", {31'b0, phase}, 32'h0);
        rst_n = 1'b1;

        // Table of ADD vectors: R4 values and flag, R3 timing
        foreach (VEC[i]) begin
            clear_code();
            load(0, mk(4'd2, 100, 101));
            load(1, mk(4'd3, 0, 1));
            load(100, VEC[i].a);
            load(101, VEC[i].b);
            chk(wb_en == 1'b0, "R11", "stopped wb_en during load", {31'b0, wb_en}, 32'h0);
            run_prog(12);
            chk(ev_n == 1, "R4", "add event count", ev_n, 1);
            chk_ev(0, 4, 100, VEC[i].sum, "R3");
            chk(z_last == VEC[i].z, "R4", "add zero flag", {31'b0, z_last}, {31'b0, VEC[i].z});
        end
        // R1: phase sequence at run start (from the last table run)
        chk(ph_t[0] == 1'b0 && ph_t[1] == 1'b1 && ph_t[2] == 1'b0 && ph_t[3] == 1'b1,
            "R1", "phase pattern", {28'b0, ph_t[3], ph_t[2], ph_t[1], ph_t[0]}, 32'hA);
        chk(fp_t[0] == 9'd0, "R3", "first fetch address", {23'b0, fp_t[0]}, 32'h0);

        // R5 / R2: operand forwarding, back-to-back write-backs
        clear_code();
        load(0, mk(4'd2, 100, 101));
        load(1, mk(4'd2, 102, 100));
        load(2, mk(4'd2, 102, 102));
        load(3, mk(4'd3, 0, 3));
        load(100, 32'd5); load(101, 32'd7); load(102, 32'd1);
        run_prog(14);
        chk(ev_n == 3, "R2", "forward event count", ev_n, 3);
        chk_ev(0, 4, 100, 32'd12, "R2");
        chk_ev(1, 6, 102, 32'd13, "R5");
        chk_ev(2, 8, 102, 32'd26, "R5");

        // R6: modified code executes after one spacer
        clear_code();
        load(0, mk(4'd1, 2, 110));
        load(3, mk(4'd3, 0, 3));
        load(110, mk(4'd1, 104, 105));
        load(105, 32'h77);
        run_prog(14);
        chk(ev_n == 2, "R6", "self-modify event count", ev_n, 2);
        chk_ev(0, 4, 2, mk(4'd1, 104, 105), "R6");
        chk_ev(1, 8, 104, 32'h77, "R6");

        // R8 / R10: jump timing, cancelled ADD neither writes nor flags
        clear_code();
        load(0, mk(4'd3, 0, 5));
        load(1, mk(4'd2, 106, 107));
        load(5, mk(4'd1, 108, 109));
        load(6, mk(4'd3, 0, 6));
        load(106, 32'h0); load(107, 32'h0); load(109, 32'h99);
        run_prog(14);
        chk(fp_t[4] == 9'd5, "R8", "jump target fetch at cycle 4", {23'b0, fp_t[4]}, 32'd5);
        chk(ev_n == 1, "R8", "cancelled instr write-back count", ev_n, 1);
        chk_ev(0, 8, 108, 32'h99, "R8");
        chk(z_last == 1'b0, "R10", "cancelled ADD flag", {31'b0, z_last}, 32'h0);

        // R7: prefix substitutes fields of the next instruction only
        clear_code();
        load(0, mk(4'd4, 120, 121));
        load(1, mk(4'd1, 50, 51));
        load(2, mk(4'd1, 52, 53));
        load(3, mk(4'd3, 0, 3));
        load(121, 32'hAA); load(51, 32'h11); load(53, 32'h55);
        run_prog(14);
        chk(ev_n == 2, "R7", "prefix event count", ev_n, 2);
        chk_ev(0, 6, 120, 32'hAA, "R7");
        chk_ev(1, 8, 52, 32'h55, "R7");

        // R9: prefix in a jump shadow leaves the target alone
        clear_code();
        load(0, mk(4'd3, 0, 4));
        load(1, mk(4'd4, 120, 121));
        load(4, mk(4'd1, 60, 61));
        load(5, mk(4'd3, 0, 5));
        load(61, 32'h66); load(121, 32'hAA);
        run_prog(14);
        chk(ev_n == 1, "R9", "cancelled prefix event count", ev_n, 1);
        chk_ev(0, 8, 60, 32'h66, "R9");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule